// File: doc/BRIEF.md
# Power Fail and Protection Sequencer

This block supervises the supply of a motor power controller and steps it through power-up, shutdown and restart. It takes digitised indications of supply good, supply low and over-temperature, each filtered by a small debounce counter. It also takes an over-velocity indication from the actuator. Its outputs are a power-on reset, a reset for the control and converter registers, and enables for spindle tristate, actuator retract and dynamic brake. It also drives a lock that keeps the actuator driver off after an over-velocity event, and a sleep flag.

When power is applied, every driver is held off and reset stays asserted until the filtered supply-good indication is seen. Reset is then held for a programmable number of clocks. In run, a low supply, a loss of supply good or an over-temperature event starts an ordered shutdown. The steps are register reset, then spindle tristate, then actuator retract, then the dynamic brake after a delay. The full sequence always runs to the end, even if the supply recovers during it. Only then does the power-up reset delay start again. All delays are clock counters. The input indications are taken as already synchronous to `clk`.

Top module: `pwr_guard_seq`

## Requirements
- R1: While `rst_n` is low and right after it, `por_n`=0, `reg_rst`=1, `spin_tristate`=1, `retract_en`=0, `brake_en`=0, `vcm_lock`=0, `sleep_mode`=0.
- R2: With `lowv_in` and `otemp_in` low, `por_n` rises exactly DEB_LEN+1+POR_DLY rising clock edges after `vgood_in` goes high and stays high. At that point `reg_rst` and `spin_tristate` fall.
- R3: In run, a high `lowv_in`, a high `otemp_in` or a low `vgood_in`, held for DEB_LEN cycles, makes `reg_rst` rise and `por_n` fall exactly DEB_LEN+1 edges after the input change.
- R4: After shutdown begins, `spin_tristate` rises RST_CYC edges after `reg_rst`. `retract_en` rises TRI_CYC edges after that, and `brake_en` rises BRAKE_DLY edges after `retract_en`. Each stage keeps the outputs of the earlier stages asserted.
- R5: The brake stays on for BRAKE_HOLD edges. Then `brake_en` and `retract_en` fall, while `reg_rst` and `spin_tristate` stay high and the block re-enters power-up.
- R6: A return of good supply during shutdown does not shorten the sequence. `por_n` rises exactly POR_DLY+1 edges after the brake is released, provided the filtered indications are good by then.
- R7: An input pulse shorter than DEB_LEN cycles has no effect. `por_n` stays high and `reg_rst` stays low.
- R8: `ovel_in` high sets `vcm_lock` on the next edge. The lock then stays set while `ovel_clr` is low.
- R9: `vcm_lock` clears on the edge after `ovel_clr` is high only while `ovel_in` is low. `ovel_clr` with `ovel_in` high leaves the lock set.
- R10: `sleep_mode` is 1 exactly when the block is in run (`por_n`=1) and both `vcm_en_bit` and `spin_en_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| vgood_in | input | 1 | Supply-good indication, high when good |
| lowv_in | input | 1 | Low-supply trip indication |
| otemp_in | input | 1 | Over-temperature indication |
| ovel_in | input | 1 | Actuator over-velocity indication |
| ovel_clr | input | 1 | Processor clear of the over-velocity lock |
| vcm_en_bit | input | 1 | Actuator driver enable bit from the control register |
| spin_en_bit | input | 1 | Spindle driver enable bit from the control register |
| por_n | output | 1 | Power-on reset, active low |
| reg_rst | output | 1 | Reset of control and converter registers (converter commands to zero) |
| spin_tristate | output | 1 | Spindle power outputs to high impedance |
| retract_en | output | 1 | Actuator retract enable |
| brake_en | output | 1 | Spindle dynamic brake enable |
| vcm_lock | output | 1 | Holds the actuator driver off after over-velocity |
| sleep_mode | output | 1 | Both drivers disabled, low-power state |

## Verification
On every cycle, the assertions check the nesting of the shutdown outputs: brake implies retract, retract implies tristate, and tristate implies register reset. They also check that the brake comes up only after exactly BRAKE_DLY cycles of retract, the set and hold of the over-velocity lock, and the sleep condition. They also check that reset releases only after a filtered supply-good. The exact cycle counts of the power-up delay, the debounce filter and each shutdown stage are shown by the bench scenarios. So are the rejection of short glitches, the completion of a sequence when power returns midway, and restart after an over-temperature event.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    PS_PWRUP,
    PS_PORDLY,
    PS_RUN,
    PS_SD_RST,
    PS_SD_TRI,
    PS_SD_RET,
    PS_SD_BRK
  } pfs_state_e;

  typedef struct packed {
    logic por_n;
    logic reg_rst;
    logic spin_tri;
    logic retract;
    logic brake;
  } pfs_drv_t;

  localparam int CH_VGOOD = 0;
  localparam int CH_LOWV  = 1;
  localparam int CH_OTEMP = 2;
  localparam int NUM_CH   = 3;

  function automatic int unsigned pfs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // True on the final cycle of a window of 'len' cycles counted from zero.
  function automatic logic pfs_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Output pattern for each state; later shutdown stages keep earlier ones.
  function automatic pfs_drv_t pfs_decode(input pfs_state_e s);
    pfs_drv_t d;
    d = '{por_n: 1'b0, reg_rst: 1'b1, spin_tri: 1'b1, retract: 1'b0, brake: 1'b0};
    case (s)
      PS_RUN:    d = '{por_n: 1'b1, reg_rst: 1'b0, spin_tri: 1'b0, retract: 1'b0, brake: 1'b0};
      PS_SD_RST: d = '{por_n: 1'b0, reg_rst: 1'b1, spin_tri: 1'b0, retract: 1'b0, brake: 1'b0};
      PS_SD_TRI: d = '{por_n: 1'b0, reg_rst: 1'b1, spin_tri: 1'b1, retract: 1'b0, brake: 1'b0};
      PS_SD_RET: d = '{por_n: 1'b0, reg_rst: 1'b1, spin_tri: 1'b1, retract: 1'b1, brake: 1'b0};
      PS_SD_BRK: d = '{por_n: 1'b0, reg_rst: 1'b1, spin_tri: 1'b1, retract: 1'b1, brake: 1'b1};
      default:   ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pfs_debounce.sv
module pfs_debounce #(
  parameter int unsigned DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  import pfs_pkg::*;

  localparam int DW = $clog2(DEB_LEN + 1);

  logic [DW-1:0] cnt_q;
  logic          differs;

  assign differs = (raw != filt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      filt  <= 1'b0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (pfs_last(32'(cnt_q), DEB_LEN)) begin
      cnt_q <= '0;
      filt  <= raw;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pfs_seq_fsm.sv
module pfs_seq_fsm #(
  parameter int unsigned POR_DLY    = 20,
  parameter int unsigned RST_CYC    = 2,
  parameter int unsigned TRI_CYC    = 3,
  parameter int unsigned BRAKE_DLY  = 10,
  parameter int unsigned BRAKE_HOLD = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vgood_f,
  input  logic                lowv_f,
  input  logic                otemp_f,
  output pfs_pkg::pfs_drv_t   drv
);
  import pfs_pkg::*;

  localparam int unsigned MAXLEN =
    pfs_max(pfs_max(pfs_max(POR_DLY, RST_CYC), pfs_max(TRI_CYC, BRAKE_DLY)), BRAKE_HOLD);
  localparam int CW = $clog2(MAXLEN + 1);

  pfs_state_e    st_q, st_nxt;
  logic [CW-1:0] cnt_q;
  logic          fault;
  logic          stage_end;

  function automatic int unsigned stage_len(input pfs_state_e s);
    case (s)
      PS_PORDLY: return POR_DLY;
      PS_SD_RST: return RST_CYC;
      PS_SD_TRI: return TRI_CYC;
      PS_SD_RET: return BRAKE_DLY;
      PS_SD_BRK: return BRAKE_HOLD;
      default:   return 1;
    endcase
  endfunction

  assign fault     = !vgood_f || lowv_f || otemp_f;
  assign stage_end = pfs_last(32'(cnt_q), stage_len(st_q));

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      PS_PWRUP:  if (!fault) st_nxt = PS_PORDLY;
      PS_PORDLY: if (fault) st_nxt = PS_PWRUP;
                 else if (stage_end) st_nxt = PS_RUN;
      PS_RUN:    if (fault) st_nxt = PS_SD_RST;
      PS_SD_RST: if (stage_end) st_nxt = PS_SD_TRI;
      PS_SD_TRI: if (stage_end) st_nxt = PS_SD_RET;
      PS_SD_RET: if (stage_end) st_nxt = PS_SD_BRK;
      PS_SD_BRK: if (stage_end) st_nxt = PS_PWRUP;
      default:   st_nxt = PS_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_PWRUP;
      cnt_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_nxt != st_q || st_q == PS_PWRUP || st_q == PS_RUN)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign drv = pfs_decode(st_q);

endmodule

// File: rtl/pfs_ovel_latch.sv
module pfs_ovel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ovel_raw,
  input  logic clr,
  output logic lock
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock <= 1'b0;
    else if (ovel_raw) lock <= 1'b1;
    else if (clr)      lock <= 1'b0;
  end

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq #(
  parameter int unsigned DEB_LEN    = 4,
  parameter int unsigned POR_DLY    = 20,
  parameter int unsigned RST_CYC    = 2,
  parameter int unsigned TRI_CYC    = 3,
  parameter int unsigned BRAKE_DLY  = 10,
  parameter int unsigned BRAKE_HOLD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vgood_in,
  input  logic lowv_in,
  input  logic otemp_in,
  input  logic ovel_in,
  input  logic ovel_clr,
  input  logic vcm_en_bit,
  input  logic spin_en_bit,
  output logic por_n,
  output logic reg_rst,
  output logic spin_tristate,
  output logic retract_en,
  output logic brake_en,
  output logic vcm_lock,
  output logic sleep_mode
);
  import pfs_pkg::*;

  logic [NUM_CH-1:0] raw_vec;
  logic [NUM_CH-1:0] filt_vec;
  logic              vgood_f, lowv_f, otemp_f;
  pfs_drv_t          drv;

  assign raw_vec[CH_VGOOD] = vgood_in;
  assign raw_vec[CH_LOWV]  = lowv_in;
  assign raw_vec[CH_OTEMP] = otemp_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_deb
    pfs_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_vec[g]),
      .filt (filt_vec[g])
    );
  end

  assign vgood_f = filt_vec[CH_VGOOD];
  assign lowv_f  = filt_vec[CH_LOWV];
  assign otemp_f = filt_vec[CH_OTEMP];

  pfs_seq_fsm #(
    .POR_DLY   (POR_DLY),
    .RST_CYC   (RST_CYC),
    .TRI_CYC   (TRI_CYC),
    .BRAKE_DLY (BRAKE_DLY),
    .BRAKE_HOLD(BRAKE_HOLD)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .vgood_f(vgood_f),
    .lowv_f (lowv_f),
    .otemp_f(otemp_f),
    .drv    (drv)
  );

  pfs_ovel_latch u_ovel (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovel_raw(ovel_in),
    .clr     (ovel_clr),
    .lock    (vcm_lock)
  );

  assign por_n         = drv.por_n;
  assign reg_rst       = drv.reg_rst;
  assign spin_tristate = drv.spin_tri;
  assign retract_en    = drv.retract;
  assign brake_en      = drv.brake;
  assign sleep_mode    = drv.por_n && !vcm_en_bit && !spin_en_bit;

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int unsigned BRAKE_DLY = 10
) (
  input logic clk,
  input logic rst_n,
  input logic lowv_in,
  input logic ovel_in,
  input logic ovel_clr,
  input logic vcm_en_bit,
  input logic spin_en_bit,
  input logic vgood_f,
  input logic lowv_f,
  input logic por_n,
  input logic reg_rst,
  input logic spin_tristate,
  input logic retract_en,
  input logic brake_en,
  input logic vcm_lock,
  input logic sleep_mode
);

  localparam int RW = $clog2(BRAKE_DLY + 2);

  logic [RW-1:0] ret_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ret_cnt <= '0;
    else if (!retract_en)           ret_cnt <= '0;
    else if (!brake_en && ret_cnt <= RW'(BRAKE_DLY)) ret_cnt <= ret_cnt + 1'b1;
  end

  AST_POR_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> $past(vgood_f)); // R2
  AST_TRI_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    spin_tristate |-> reg_rst); // R4
  AST_RET_NEEDS_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    retract_en |-> spin_tristate); // R4
  AST_BRK_NEEDS_RET: assert property (@(posedge clk) disable iff (!rst_n)
    brake_en |-> retract_en); // R4
  AST_BRAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brake_en) |-> ret_cnt == RW'(BRAKE_DLY)); // R4
  AST_DEB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lowv_f) |-> $past(lowv_in)); // R7
  AST_OVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovel_in |=> vcm_lock); // R8
  AST_OVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vcm_lock && !ovel_clr) |=> vcm_lock); // R9
  AST_SLEEP_COND: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_mode |-> (por_n && !vcm_en_bit && !spin_en_bit)); // R10

endmodule

bind pwr_guard_seq pfs_checker #(.BRAKE_DLY(BRAKE_DLY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lowv_in      (lowv_in),
  .ovel_in      (ovel_in),
  .ovel_clr     (ovel_clr),
  .vcm_en_bit   (vcm_en_bit),
  .spin_en_bit  (spin_en_bit),
  .vgood_f      (vgood_f),
  .lowv_f       (lowv_f),
  .por_n        (por_n),
  .reg_rst      (reg_rst),
  .spin_tristate(spin_tristate),
  .retract_en   (retract_en),
  .brake_en     (brake_en),
  .vcm_lock     (vcm_lock),
  .sleep_mode   (sleep_mode)
);

// File: tb/tb_pwr_guard_seq.sv
module tb_pwr_guard_seq;

  localparam int CLK_P = 10;
  localparam int DEB   = 4;
  localparam int PDLY  = 20;
  localparam int RC    = 2;
  localparam int TC    = 3;
  localparam int BD    = 10;
  localparam int BH    = 6;

  logic clk = 1'b0;
  logic rst_n, vgood_in, lowv_in, otemp_in, ovel_in, ovel_clr, vcm_en_bit, spin_en_bit;
  logic por_n, reg_rst, spin_tristate, retract_en, brake_en, vcm_lock, sleep_mode;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_guard_seq #(
    .DEB_LEN(DEB), .POR_DLY(PDLY), .RST_CYC(RC), .TRI_CYC(TC),
    .BRAKE_DLY(BD), .BRAKE_HOLD(BH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .vgood_in(vgood_in), .lowv_in(lowv_in),
    .otemp_in(otemp_in), .ovel_in(ovel_in), .ovel_clr(ovel_clr),
    .vcm_en_bit(vcm_en_bit), .spin_en_bit(spin_en_bit), .por_n(por_n),
    .reg_rst(reg_rst), .spin_tristate(spin_tristate), .retract_en(retract_en),
    .brake_en(brake_en), .vcm_lock(vcm_lock), .sleep_mode(sleep_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sel_val(input int s);
    case (s)
      0: return por_n;
      1: return reg_rst;
      2: return spin_tristate;
      3: return retract_en;
      default: return brake_en;
    endcase
  endfunction

  // Count rising edges until the selected output shows 'v' at a falling edge.
  task automatic edges_until(input int s, input logic v, output int n);
    n = 0;
    while (sel_val(s) !== v && n < 5000) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vgood_in = 0; lowv_in = 0; otemp_in = 0; ovel_in = 0;
    ovel_clr = 0; vcm_en_bit = 0; spin_en_bit = 0;
    idle(3);
    chk("R1 por_n", por_n, 0);
    chk("R1 reg_rst", reg_rst, 1);
    chk("R1 tristate", spin_tristate, 1);
    chk("R1 retract", retract_en, 0);
    chk("R1 brake", brake_en, 0);
    chk("R1 vcm_lock", vcm_lock, 0);
    chk("R1 sleep", sleep_mode, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 por_n after release", por_n, 0);
  endtask

  task automatic t_powerup();
    int n;
    vgood_in = 1'b1;
    edges_until(0, 1'b1, n);
    chk("R2 por delay", n, DEB + 1 + PDLY);
    chk("R2 reg_rst low", reg_rst, 0);
    chk("R2 tristate low", spin_tristate, 0);
  endtask

  task automatic t_sleep();
    vcm_en_bit = 0; spin_en_bit = 0; idle(1);
    chk("R10 sleep both off", sleep_mode, 1);
    vcm_en_bit = 1; idle(1);
    chk("R10 vcm on", sleep_mode, 0);
    vcm_en_bit = 0; spin_en_bit = 1; idle(1);
    chk("R10 spin on", sleep_mode, 0);
    spin_en_bit = 0;
  endtask

  task automatic t_glitch();
    lowv_in = 1'b1; idle(DEB - 1);
    lowv_in = 1'b0; idle(DEB + 4);
    chk("R7 por_n kept", por_n, 1);
    chk("R7 reg_rst kept", reg_rst, 0);
  endtask

  // Full ordered shutdown started by lowv; cause removed after 'early' edges.
  task automatic t_shutdown(input string tag, input int early);
    int n;
    lowv_in = 1'b1;
    edges_until(1, 1'b1, n);
    chk({tag, " R3 reset start"}, n, DEB + 1);
    chk({tag, " R3 por_n low"}, por_n, 0);
    if (early > 0) lowv_in = 1'b0;
    edges_until(2, 1'b1, n);
    chk({tag, " R4 tristate"}, n, RC);
    edges_until(3, 1'b1, n);
    chk({tag, " R4 retract"}, n, TC);
    chk({tag, " R4 tristate held"}, spin_tristate, 1);
    edges_until(4, 1'b1, n);
    chk({tag, " R4 brake"}, n, BD);
    edges_until(4, 1'b0, n);
    chk({tag, " R5 brake hold"}, n, BH);
    chk({tag, " R5 retract off"}, retract_en, 0);
    chk({tag, " R5 reset kept"}, reg_rst, 1);
    chk({tag, " R5 tristate kept"}, spin_tristate, 1);
    if (early > 0) begin
      edges_until(0, 1'b1, n);
      chk({tag, " R6 restart delay"}, n, PDLY + 1);
    end else begin
      lowv_in = 1'b0;
      edges_until(0, 1'b1, n);
      chk({tag, " R5 restart after clear"}, n, DEB + 1 + PDLY);
    end
  endtask

  task automatic t_otemp();
    int n;
    otemp_in = 1'b1;
    edges_until(1, 1'b1, n);
    chk("R3 otemp trip", n, DEB + 1);
    otemp_in = 1'b0;
    edges_until(4, 1'b1, n);
    chk("R4 otemp brake", n, RC + TC + BD);
    edges_until(0, 1'b1, n);
    chk("R6 otemp restart", n, BH + PDLY + 1);
  endtask

  task automatic t_vgood_loss();
    int n;
    vgood_in = 1'b0;
    edges_until(1, 1'b1, n);
    chk("R3 vgood loss", n, DEB + 1);
    vgood_in = 1'b1;
    edges_until(0, 1'b1, n);
    chk("R6 vgood restart", n, RC + TC + BD + BH + PDLY + 1);
  endtask

  task automatic t_ovel();
    ovel_in = 1'b1; idle(1);
    chk("R8 lock set", vcm_lock, 1);
    ovel_in = 1'b0; idle(5);
    chk("R8 lock held", vcm_lock, 1);
    ovel_in = 1'b1; ovel_clr = 1'b1; idle(1);
    chk("R9 clear ignored while active", vcm_lock, 1);
    ovel_in = 1'b0; idle(1);
    chk("R9 clear with input low", vcm_lock, 0);
    ovel_clr = 1'b0; idle(2);
    chk("R9 stays clear", vcm_lock, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_powerup();
    t_sleep();
    t_glitch();
    t_shutdown("lowv", 0);
    t_shutdown("early-return", 1);
    t_otemp();
    t_vgood_loss();
    t_ovel();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule